// File: doc/BRIEF.md
# Prescaled Reloading Down-Counter Timer Channel

This block is a single timer channel for a peripheral bus. Software loads a 32-bit reload constant and a live count through a word-addressed register port, picks a clock divider in a control register, and raises a separate run input to let the channel count. A prescaler divides the peripheral clock by a power of four. Each prescaled tick lowers the count by one. A tick that arrives while the count is zero reloads it from the constant, sets an underflow flag, and counting goes on.

The flag stays set until software writes the control register with the flag bit at zero. The interrupt output is a level: the flag gated by an enable bit. Control writes that carry reserved codes, and any access to the capture register on a channel built without capture, do nothing except raise a one-cycle error pulse. A two-flop stage releases the asynchronous active-low reset in step with the clock.

Top module: `ptmr_channel`

## Requirements
- R1: After reset the reload constant and the count read 0xFFFFFFFF, control reads 0, and the interrupt and error outputs are low.
- R2: Byte address bits [3:2] pick the register: 0 is the reload constant, 1 the count, 2 control, 3 capture. The reload constant and the count read back what was written.
- R3: Control bits [2:0] pick the divider. Codes 0 to 4 divide by 4, 16, 64, 256 and 1024. A write to the count restarts the prescaler, so the first decrement lands on the divisor-th running cycle after that write.
- R4: A tick that arrives while the count is 0 loads the count from the reload constant and sets the underflow flag. Counting then continues.
- R5: Control bit 8 reads as the underflow flag. A control write with bit 8 = 0 clears the flag. Writing 1 to bit 8 neither sets the flag nor is stored.
- R6: The interrupt output is high exactly when the underflow flag is set and control bit 5 (interrupt enable) is 1.
- R7: While the run input is low, the prescaler and the count hold their values and the flag cannot set.
- R8: Writing the reload constant leaves the current count unchanged.
- R9: A control write is ignored, flag clear included, and the error output pulses high for one cycle when it carries any of these: divider code 5; code 6 or 7 without the external-clock option; nonzero bits [4:3] without that option; capture bits [7:6] = 1; nonzero bits [7:6] or bit 9 without the capture option; or any bit from 10 upward.
- R10: On a channel without capture, a read or write at register 3 pulses the error output, reads return 0, and no register changes.
- R11: When an underflow and a flag-clearing control write hit the same edge, the flag ends up set. When a tick and a count write hit the same edge, the written value wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Counting enable for this channel |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | Write qualifier for the access |
| bus_rd_i | input | 1 | Read qualifier for the access |
| bus_addr_i | input | 2 | Byte address bits [3:2], the register select |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the selected register, combinational |
| irq_o | output | 1 | Level interrupt request |
| err_o | output | 1 | One-cycle pulse for a rejected access |

## Verification
Two pairs of events can land on the same clock edge. One pair is the underflow that sets the flag and a software write that clears it. The other is a prescaled tick and a software write of the count. The bench lets the prescaler run to its last phase, then times the control write, or the count write, to land on the edge that carries the tick. It checks that the flag reads set and that the count reads the written value instead of the decremented one. Neighbouring cases are judged against counts computed from the divisor: the first decrement after a count write, hold while stopped, and reload at underflow.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_CAPT   = 2'd3
  } reg_sel_e;

  localparam int CTRL_W = 16;

  // Control word, most significant field first
  typedef struct packed {
    logic [5:0] rsv;
    logic       cflag;
    logic       uflag;
    logic [1:0] capc;
    logic       ien;
    logic [1:0] edg;
    logic [2:0] psc;
  } ctrl_t;

endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int NUM_DIV = 5,
  localparam int PW = 2 * NUM_DIV
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic [2:0] code_i,
  output logic       tick_o
);

  logic [PW-1:0] pre_q, pre_d, lim;
  logic          code_ok, wrap, pre_en;

  // Terminal phase: 4^(code+1) - 1
  always_comb begin
    lim     = '0;
    code_ok = 1'b0;
    for (int i = 0; i < NUM_DIV; i++) begin
      if (code_i == 3'(i)) begin
        lim     = PW'((1 << (2 * (i + 1))) - 1);
        code_ok = 1'b1;
      end
    end
  end

  always_comb begin
    wrap   = run_i & code_ok & (pre_q >= lim);
    tick_o = wrap & ~restart_i;
    pre_en = restart_i | (run_i & code_ok);
    if (restart_i)  pre_d = '0;
    else if (wrap)  pre_d = '0;
    else            pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  // R7: stopped channel keeps its prescaler phase
  a_r7_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !restart_i) |=> $stable(pre_q));

  // R3: a count write restarts the phase
  a_r3_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (pre_q == '0));

endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] count_o,
  output logic         uflow_o
);

  logic [W-1:0] count_q, count_d;
  logic         at_zero, count_en;

  always_comb begin
    at_zero  = (count_q == '0);
    uflow_o  = tick_i & at_zero & ~load_i;
    count_en = load_i | tick_i;
    if (load_i)       count_d = load_val_i;
    else if (at_zero) count_d = reload_i;
    else              count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '1;
    else if (count_en) count_q <= count_d;
  end

  assign count_o = count_q;

  // R4: underflow reloads from the constant
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_o |=> (count_q == $past(reload_i)));

  // R7: no tick and no write, no change
  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(count_q));

  // R11: software write beats a coincident tick
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_q == $past(load_val_i)));

endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int W        = 32,
  parameter int NUM_DIV  = 5,
  parameter bit HAS_CAPT = 1'b0,
  parameter bit HAS_EXT  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_i,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] count_i,
  input  logic         uflow_i,
  output logic [W-1:0] reload_o,
  output logic [2:0]   psc_o,
  output logic         cnt_load_o,
  output logic [W-1:0] rdata_o,
  output logic         irq_o,
  output logic         err_o
);

  reg_sel_e     rsel;
  ctrl_t        wr_ctrl, ctrl_q, ctrl_store, rd_ctrl;
  logic [W-1:0] reload_q, capt_q;
  logic         flag_q, flag_d, err_q, err_d;
  logic         wr_reload, wr_ctrl_sel, ctrl_bad, ctrl_ok, capt_acc, capt_bad;
  logic         psc_bad, edg_bad, capc_bad, high_bad;

  always_comb begin
    rsel        = reg_sel_e'(addr_i);
    wr_ctrl     = ctrl_t'(wdata_i[CTRL_W-1:0]);
    wr_reload   = sel_i & wr_i & (rsel == SEL_RELOAD);
    cnt_load_o  = sel_i & wr_i & (rsel == SEL_COUNT);
    wr_ctrl_sel = sel_i & wr_i & (rsel == SEL_CTRL);
    capt_acc    = sel_i & (wr_i | rd_i) & (rsel == SEL_CAPT);

    psc_bad  = (wr_ctrl.psc >= 3'(NUM_DIV)) & ~(HAS_EXT & (wr_ctrl.psc >= 3'd6));
    edg_bad  = (wr_ctrl.edg != 2'd0) & ~HAS_EXT;
    capc_bad = (wr_ctrl.capc == 2'd1) |
               (((wr_ctrl.capc != 2'd0) | wr_ctrl.cflag) & ~HAS_CAPT);
    high_bad = (wr_ctrl.rsv != '0) | (wdata_i[W-1:CTRL_W] != '0);
    ctrl_bad = psc_bad | edg_bad | capc_bad | high_bad;

    ctrl_ok  = wr_ctrl_sel & ~ctrl_bad;
    capt_bad = capt_acc & ~HAS_CAPT;
    err_d    = (wr_ctrl_sel & ctrl_bad) | capt_bad;

    ctrl_store       = wr_ctrl;
    ctrl_store.uflag = 1'b0;
    ctrl_store.cflag = 1'b0;

    // Underflow takes priority over a clearing write
    if (uflow_i)                       flag_d = 1'b1;
    else if (ctrl_ok & ~wr_ctrl.uflag) flag_d = 1'b0;
    else                               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '1;
    else if (wr_reload) reload_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_ok) ctrl_q <= ctrl_store;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      err_q  <= err_d;
    end
  end

  generate
    if (HAS_CAPT) begin : g_capt
      logic capt_wr;
      assign capt_wr = capt_acc & wr_i;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       capt_q <= '0;
        else if (capt_wr) capt_q <= wdata_i;
      end
    end else begin : g_nocapt
      assign capt_q = '0;
    end
  endgenerate

  always_comb begin
    rd_ctrl       = ctrl_q;
    rd_ctrl.uflag = flag_q;
    case (rsel)
      SEL_RELOAD: rdata_o = reload_q;
      SEL_COUNT:  rdata_o = count_i;
      SEL_CTRL:   rdata_o = {{(W-CTRL_W){1'b0}}, rd_ctrl};
      default:    rdata_o = capt_q;
    endcase
  end

  assign reload_o = reload_q;
  assign psc_o    = ctrl_q.psc;
  assign irq_o    = flag_q & ctrl_q.ien;
  assign err_o    = err_q;

  // R9: a rejected control write leaves control untouched
  a_r9_ctrl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl_sel && ctrl_bad) |=> $stable(ctrl_q));

  // R9: and does not clear the flag either
  a_r9_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl_sel && ctrl_bad && flag_q) |=> flag_q);

  // R11: an underflow always leaves the flag set
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_i |=> flag_q);

  // R5: only an underflow can raise the flag
  a_r5_no_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(uflow_i));

endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel #(
  parameter int DATA_W   = 32,
  parameter int NUM_DIV  = 5,
  parameter bit HAS_CAPT = 1'b0,
  parameter bit HAS_EXT  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [3:2]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              err_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_sn;
  logic              tick, uflow, cnt_load;
  logic [2:0]        psc;
  logic [DATA_W-1:0] reload, count;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  ptmr_prescale #(.NUM_DIV(NUM_DIV)) u_pre (
    .clk       (clk),
    .rst_n     (rst_sn),
    .run_i     (run_i),
    .restart_i (cnt_load),
    .code_i    (psc),
    .tick_o    (tick)
  );

  ptmr_count #(.W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sn),
    .tick_i     (tick),
    .load_i     (cnt_load),
    .load_val_i (bus_wdata_i),
    .reload_i   (reload),
    .count_o    (count),
    .uflow_o    (uflow)
  );

  ptmr_regs #(
    .W        (DATA_W),
    .NUM_DIV  (NUM_DIV),
    .HAS_CAPT (HAS_CAPT),
    .HAS_EXT  (HAS_EXT)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sn),
    .sel_i      (bus_sel_i),
    .wr_i       (bus_wr_i),
    .rd_i       (bus_rd_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .count_i    (count),
    .uflow_i    (uflow),
    .reload_o   (reload),
    .psc_o      (psc),
    .cnt_load_o (cnt_load),
    .rdata_o    (bus_rdata_o),
    .irq_o      (irq_o),
    .err_o      (err_o)
  );

  // R7: a stopped channel never underflows
  a_r7_no_uflow_stopped: assert property (@(posedge clk) disable iff (!rst_sn)
    !run_i |-> !uflow);

endmodule

// File: tb/ptmr_channel_tb.sv
`timescale 1ns/1ps
module ptmr_channel_tb;

  localparam logic [3:0] OP_WR = 4'd0, OP_RD = 4'd1, OP_IDLE = 4'd2, OP_RUN = 4'd3,
                         OP_WRE = 4'd4, OP_RDE = 4'd5, OP_IRQ = 4'd6;
  localparam int NV = 88;

  // {op, byte address, requirement number, data, expected}
  localparam logic [75:0] VEC [NV] = '{
    {OP_WR,  4'h0, 4'd2,  32'd5,     32'd0},       // R2
    {OP_WR,  4'h4, 4'd2,  32'd2,     32'd0},
    {OP_RD,  4'h0, 4'd2,  32'd0,     32'd5},
    {OP_RD,  4'h4, 4'd2,  32'd0,     32'd2},
    {OP_RUN, 4'h0, 4'd0,  32'd1,     32'd0},
    {OP_IDLE,4'h0, 4'd0,  32'd8,     32'd0},
    {OP_RUN, 4'h0, 4'd0,  32'd0,     32'd0},
    {OP_RD,  4'h4, 4'd3,  32'd0,     32'd0},       // R3 divide by 4
    {OP_RUN, 4'h0, 4'd0,  32'd1,     32'd0},
    {OP_IDLE,4'h0, 4'd0,  32'd3,     32'd0},
    {OP_RUN, 4'h0, 4'd0,  32'd0,     32'd0},
    {OP_RD,  4'h4, 4'd4,  32'd0,     32'd0},       // R4 not yet
    {OP_RD,  4'h8, 4'd4,  32'd0,     32'd0},
    {OP_RUN, 4'h0, 4'd0,  32'd1,     32'd0},
    {OP_IDLE,4'h0, 4'd0,  32'd1,     32'd0},
    {OP_RUN, 4'h0, 4'd0,  32'd0,     32'd0},
    {OP_RD,  4'h4, 4'd4,  32'd0,     32'd5},       // R4 reload
    {OP_RD,  4'h8, 4'd5,  32'd0,     32'h100},     // R5 flag in bit 8
    {OP_IRQ, 4'h0, 4'd6,  32'd0,     32'd0},       // R6
    {OP_WR,  4'h8, 4'd5,  32'h120,   32'd0},
    {OP_RD,  4'h8, 4'd5,  32'd0,     32'h120},
    {OP_IRQ, 4'h0, 4'd6,  32'd0,     32'd1},
    {OP_WR,  4'h8, 4'd5,  32'h020,   32'd0},
    {OP_RD,  4'h8, 4'd5,  32'd0,     32'h020},
    {OP_IRQ, 4'h0, 4'd6,  32'd0,     32'd0},
    {OP_WR,  4'h8, 4'd5,  32'h100,   32'd0},
    {OP_RD,  4'h8, 4'd5,  32'd0,     32'h000},     // R5 one neither sets nor stores
    {OP_WR,  4'h8, 4'd3,  32'h001,   32'd0},
    {OP_WR,  4'h4, 4'd3,  32'd3,     32'd0},
    {OP_RUN, 4'h0, 4'd0,  32'd1,     32'd0},
    {OP_IDLE,4'h0, 4'd0,  32'd15,    32'd0},
    {OP_RUN, 4'h0, 4'd0,  32'd0,     32'd0},
    {OP_RD,  4'h4, 4'd3,  32'd0,     32'd3},       // R3 divide by 16
    {OP_RUN, 4'h0, 4'd0,  32'd1,     32'd0},
    {OP_IDLE,4'h0, 4'd0,  32'd1,     32'd0},
    {OP_RUN, 4'h0, 4'd0,  32'd0,     32'd0},
    {OP_RD,  4'h4, 4'd3,  32'd0,     32'd2},
    {OP_IDLE,4'h0, 4'd0,  32'd40,    32'd0},
    {OP_RD,  4'h4, 4'd7,  32'd0,     32'd2},       // R7 hold
    {OP_WR,  4'h0, 4'd8,  32'd9,     32'd0},
    {OP_RD,  4'h4, 4'd8,  32'd0,     32'd2},       // R8
    {OP_RD,  4'h0, 4'd2,  32'd0,     32'd9},
    {OP_WR,  4'h8, 4'd3,  32'h002,   32'd0},
    {OP_WR,  4'h4, 4'd3,  32'd1,     32'd0},
    {OP_RUN, 4'h0, 4'd0,  32'd1,     32'd0},
    {OP_IDLE,4'h0, 4'd0,  32'd64,    32'd0},
    {OP_RUN, 4'h0, 4'd0,  32'd0,     32'd0},
    {OP_RD,  4'h4, 4'd3,  32'd0,     32'd0},       // R3 divide by 64
    {OP_RUN, 4'h0, 4'd0,  32'd1,     32'd0},
    {OP_IDLE,4'h0, 4'd0,  32'd64,    32'd0},
    {OP_RUN, 4'h0, 4'd0,  32'd0,     32'd0},
    {OP_RD,  4'h4, 4'd4,  32'd0,     32'd9},
    {OP_RD,  4'h8, 4'd4,  32'd0,     32'h102},
    {OP_WR,  4'h8, 4'd3,  32'h103,   32'd0},
    {OP_WR,  4'h4, 4'd3,  32'd1,     32'd0},
    {OP_RUN, 4'h0, 4'd0,  32'd1,     32'd0},
    {OP_IDLE,4'h0, 4'd0,  32'd255,   32'd0},
    {OP_RUN, 4'h0, 4'd0,  32'd0,     32'd0},
    {OP_RD,  4'h4, 4'd3,  32'd0,     32'd1},       // R3 divide by 256
    {OP_RUN, 4'h0, 4'd0,  32'd1,     32'd0},
    {OP_IDLE,4'h0, 4'd0,  32'd1,     32'd0},
    {OP_RUN, 4'h0, 4'd0,  32'd0,     32'd0},
    {OP_RD,  4'h4, 4'd3,  32'd0,     32'd0},
    {OP_WR,  4'h8, 4'd3,  32'h104,   32'd0},
    {OP_WR,  4'h4, 4'd3,  32'd1,     32'd0},
    {OP_RUN, 4'h0, 4'd0,  32'd1,     32'd0},
    {OP_IDLE,4'h0, 4'd0,  32'd1023,  32'd0},
    {OP_RUN, 4'h0, 4'd0,  32'd0,     32'd0},
    {OP_RD,  4'h4, 4'd3,  32'd0,     32'd1},       // R3 divide by 1024
    {OP_RUN, 4'h0, 4'd0,  32'd1,     32'd0},
    {OP_IDLE,4'h0, 4'd0,  32'd1,     32'd0},
    {OP_RUN, 4'h0, 4'd0,  32'd0,     32'd0},
    {OP_RD,  4'h4, 4'd3,  32'd0,     32'd0},
    {OP_WRE, 4'h8, 4'd9,  32'h005,   32'd1},       // R9 code 5
    {OP_RD,  4'h8, 4'd9,  32'd0,     32'h104},
    {OP_WRE, 4'h8, 4'd9,  32'h006,   32'd1},
    {OP_WRE, 4'h8, 4'd9,  32'h008,   32'd1},
    {OP_WRE, 4'h8, 4'd9,  32'h040,   32'd1},
    {OP_WRE, 4'h8, 4'd9,  32'h080,   32'd1},
    {OP_WRE, 4'h8, 4'd9,  32'h200,   32'd1},
    {OP_WRE, 4'h8, 4'd9,  32'h400,   32'd1},
    {OP_WRE, 4'h8, 4'd9,  32'h10000, 32'd1},
    {OP_RD,  4'h8, 4'd9,  32'd0,     32'h104},
    {OP_WRE, 4'h8, 4'd9,  32'h000,   32'd0},
    {OP_RD,  4'h8, 4'd5,  32'd0,     32'h000},
    {OP_WRE, 4'hC, 4'd10, 32'hABCD,  32'd1},       // R10
    {OP_RDE, 4'hC, 4'd10, 32'd0,     32'd0},
    {OP_RD,  4'h4, 4'd10, 32'd0,     32'd0}
  };

  logic        clk, rst_n, run_i, bus_sel_i, bus_wr_i, bus_rd_i;
  logic [3:2]  bus_addr_i;
  logic [31:0] bus_wdata_i, bus_rdata_o;
  logic        irq_o, err_o;
  int          checks, errors;
  logic [31:0] rd_val;

  ptmr_channel u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_i),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .err_o       (err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a[3:2]; bus_wdata_i = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel_i = 1'b0; bus_wr_i = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [31:0] d);
    bus_sel_i = 1'b1; bus_rd_i = 1'b1; bus_addr_i = a[3:2];
    #2 d = bus_rdata_o;
    @(negedge clk);
    bus_sel_i = 1'b0; bus_rd_i = 1'b0;
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; run_i = 1'b0; bus_sel_i = 1'b0; bus_wr_i = 1'b0; bus_rd_i = 1'b0;
    bus_addr_i = 2'd0; bus_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(1, {31'd0, irq_o}, 32'd0);
    check(1, {31'd0, err_o}, 32'd0);
    do_read(4'h0, rd_val); check(1, rd_val, 32'hFFFF_FFFF);
    do_read(4'h4, rd_val); check(1, rd_val, 32'hFFFF_FFFF);
    do_read(4'h8, rd_val); check(1, rd_val, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  op, a, req;
      logic [31:0] d, e;
      {op, a, req, d, e} = VEC[i];
      case (op)
        OP_WR:   do_write(a, d);
        OP_RD:   begin do_read(a, rd_val); check(int'(req), rd_val, e); end
        OP_IDLE: repeat (int'(d)) @(negedge clk);
        OP_RUN:  run_i = d[0];
        OP_WRE:  begin do_write(a, d); check(int'(req), {31'd0, err_o}, e); end
        OP_RDE:  begin
                   do_read(a, rd_val);
                   check(int'(req), rd_val, e);
                   check(int'(req), {31'd0, err_o}, 32'd1);
                 end
        default: check(int'(req), {31'd0, irq_o}, e);
      endcase
    end

    // R9: the error pulse lasts a single cycle
    do_write(4'h8, 32'h005);
    check(9, {31'd0, err_o}, 32'd1);
    @(negedge clk);
    check(9, {31'd0, err_o}, 32'd0);

    // R11: underflow and flag-clearing write on the same edge
    do_write(4'h8, 32'h020);
    do_write(4'h4, 32'd0);
    run_i = 1'b1;
    repeat (3) @(negedge clk);
    do_write(4'h8, 32'h020);
    run_i = 1'b0;
    do_read(4'h8, rd_val); check(11, rd_val, 32'h120);
    check(6, {31'd0, irq_o}, 32'd1);
    do_read(4'h4, rd_val); check(4, rd_val, 32'd9);

    // R11: tick and count write on the same edge
    run_i = 1'b1;
    repeat (3) @(negedge clk);
    do_write(4'h4, 32'd7);
    run_i = 1'b0;
    do_read(4'h4, rd_val); check(11, rd_val, 32'd7);

    report();
  end

endmodule